// File: doc/BRIEF.md
# Four-Channel ADC Serial Port Responder

This block acts as the device side of the serial port of a four-input, 8-bit analog-to-digital converter. It serves as a stand-in peer for exercising a serial controller. A fast system clock oversamples the three host lines: active-low chip select, serial clock and serial data-in. The block counts serial-clock edges inside 16-clock conversion slots. From each slot it collects a control byte that picks the input for the following conversion. It returns an 8-bit value, taken from one of four parallel sample words, on the data-out line.

Each slot has three phases. The first four serial clocks carry zeros. The next eight carry the selected sample, most significant bit first. The last four carry zeros again. Output bits change after serial-clock falling edges, so a host that samples on rising edges sees a stable bit. Several slots may follow one another inside one chip-select frame. While chip select is high the output floats, a separate enable flag reports this, and every serial-clock edge is ignored.

Top module: `adc4SerialResponder`

## Requirements
- R1: While chip select is high, `dout` is high-impedance and `doutEn` is 0, and serial-clock edges have no effect. While chip select is low, `doutEn` is 1 and `dout` is driven. Both follow the pins a few system clocks later, because of the synchronizers.
- R2: `din` is captured only on rising serial-clock edges 1 to 8 of each slot. The first captured bit is bit 7 of the control byte. The value of `din` on rising edges 9 to 16 has no effect.
- R3: Control byte bits [4:3] choose the next channel. Code 00 selects channel 0 (`sampleBus[7:0]`), 01 selects channel 1 (`[15:8]`), 10 selects channel 2 (`[23:16]`) and 11 selects channel 3 (`[31:24]`). Bits 7, 6, 5, 2, 1 and 0 have no effect.
- R4: After reset, the pending channel is channel 0.
- R5: In each slot, the output after falling edges 1 to 4 is 0. After falling edges 5 to 12 it is the sample, bit 7 first. After falling edges 13 to 16 it is 0.
- R6: The sample is taken at falling edge 4 of a slot, from the pending channel at that moment. A control byte received in one slot therefore selects the next slot, which may lie in a later frame.
- R7: A new slot begins with the first falling edge after every 16th rising edge of a frame.
- R8: If the serial clock is low when chip select falls, that fall counts as falling edge 1. If the serial clock is high, the first real falling edge afterwards is falling edge 1.
- R9: Raising chip select part-way through a slot ends the transfer. The pending channel changes only if all 8 control bits were received. The next frame starts at the beginning of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data from the host |
| sampleBus | input | 32 | Four 8-bit sample words, channel 0 in the low byte |
| dout | output | 1 | Serial sample data, high-impedance while deselected |
| doutEn | output | 1 | 1 while the block drives `dout` |

## Verification
Two things can coincide in the same system clock: the chip-select fall and the first serial-clock falling edge, which happens when the clock is parked low. The bench runs frames with the serial clock parked low and with it parked high. It checks that the four leading zeros and the first data bit land on the right host rising edges in both cases. A second overlap is the control-byte commit and the end of a frame. Frames are aborted after 5 and after exactly 8 rising edges, and the channel used in the following frame shows whether the byte was taken.

// File: rtl/adcResp_pkg.sv
package adcResp_pkg;

  // Strobes from the edge/slot controller to the datapath, one system clock wide
  typedef struct packed {
    logic active;      // chip select asserted (synchronized)
    logic zeroOut;     // drive a zero bit
    logic loadSample;  // capture the pending channel's sample, drive zero
    logic shiftOut;    // drive next sample bit
    logic takeDin;     // shift in one control bit
    logic commit;      // last control bit present: update pending channel
  } strobe_t;

endpackage

// File: rtl/adcRespCtrl.sv
module adcRespCtrl
  import adcResp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_LEN    = 16,
  parameter int LEAD        = 4,
  parameter int DATA_W      = 8,
  parameter int CTRL_BITS   = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  input  logic    din,
  output strobe_t strb,
  output logic    dinS
);
  localparam int CNT_W     = $clog2(SLOT_LEN);
  localparam int DATA_LAST = LEAD + DATA_W;

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, dinPipe;
  logic csS, sclkS, csPrev, sclkPrev;
  logic csFall, active, fallEv, riseEv;
  logic [CNT_W-1:0] fallCnt, riseCnt, fallNext, riseNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      dinPipe  <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      dinPipe  <= {dinPipe[SYNC_STAGES-2:0], din};
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csS   = csPipe[SYNC_STAGES-1];
  assign sclkS = sclkPipe[SYNC_STAGES-1];
  assign dinS  = dinPipe[SYNC_STAGES-1];

  assign active = ~csS;
  assign csFall = csPrev & ~csS;
  // A chip-select fall with the clock parked low stands in for the first fall
  assign fallEv = active & (csFall ? ~sclkS : (sclkPrev & ~sclkS));
  assign riseEv = active & ~csFall & ~sclkPrev & sclkS;

  always_comb begin
    if (csFall)
      fallNext = sclkS ? '0 : CNT_W'(1);
    else if (fallCnt == CNT_W'(SLOT_LEN - 1))
      fallNext = '0;
    else
      fallNext = fallCnt + CNT_W'(1);
    riseNext = (riseCnt == CNT_W'(SLOT_LEN - 1)) ? '0 : riseCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      fallCnt <= '0;
      riseCnt <= '0;
    end else begin
      if (csFall || fallEv) fallCnt <= fallNext;
      if (csFall)           riseCnt <= '0;
      else if (riseEv)      riseCnt <= riseNext;
    end
  end

  always_comb begin
    strb            = '0;
    strb.active     = active;
    strb.loadSample = fallEv && (int'(fallNext) == LEAD);
    strb.shiftOut   = fallEv && (int'(fallNext) > LEAD) && (int'(fallNext) <= DATA_LAST);
    strb.zeroOut    = (fallEv || (active && csFall)) && !strb.loadSample && !strb.shiftOut;
    strb.takeDin    = riseEv && (int'(riseCnt) < CTRL_BITS);
    strb.commit     = riseEv && (int'(riseCnt) == CTRL_BITS - 1);
  end

  // R5
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.zeroOut, strb.loadSample, strb.shiftOut}));

endmodule

// File: rtl/adcRespData.sv
module adcRespData
  import adcResp_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_BITS = 8,
  parameter int CH_LSB    = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic                     dinS,
  input  logic [NUM_CH*DATA_W-1:0] sampleBus,
  output logic                     doutBit,
  output logic                     doutEn
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [DATA_W-1:0]    chanVal [NUM_CH];
  logic [CTRL_BITS-1:0] ctrlShift, ctrlByte;
  logic [CH_W-1:0]      pendingChan;
  logic [DATA_W-1:0]    outShift;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chanVal[c] = sampleBus[c*DATA_W +: DATA_W];
  end

  assign ctrlByte = {ctrlShift[CTRL_BITS-2:0], dinS};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlShift   <= '0;
      pendingChan <= '0;
    end else if (strb.takeDin) begin
      ctrlShift <= ctrlByte;
      if (strb.commit) pendingChan <= ctrlByte[CH_LSB +: CH_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outShift <= '0;
      doutBit  <= 1'b0;
      doutEn   <= 1'b0;
    end else begin
      doutEn <= strb.active;
      if (strb.loadSample) begin
        outShift <= chanVal[pendingChan];
        doutBit  <= 1'b0;
      end else if (strb.shiftOut) begin
        doutBit  <= outShift[DATA_W-1];
        outShift <= {outShift[DATA_W-2:0], 1'b0};
      end else if (strb.zeroOut) begin
        doutBit <= 1'b0;
      end
    end
  end

  // R9
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(pendingChan));

  // R5
  first_bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutEn) |-> !doutBit);

endmodule

// File: rtl/adc4SerialResponder.sv
module adc4SerialResponder
  import adcResp_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int SLOT_LEN    = 16,
  parameter int LEAD        = 4,
  parameter int CTRL_BITS   = 8,
  parameter int CH_LSB      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     sclk,
  input  logic                     din,
  input  logic [NUM_CH*DATA_W-1:0] sampleBus,
  output logic                     dout,
  output logic                     doutEn
);
  strobe_t strb;
  logic    dinS, doutBit;

  adcRespCtrl #(
    .SYNC_STAGES(SYNC_STAGES), .SLOT_LEN(SLOT_LEN), .LEAD(LEAD),
    .DATA_W(DATA_W), .CTRL_BITS(CTRL_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .strb(strb), .dinS(dinS)
  );

  adcRespData #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CTRL_BITS(CTRL_BITS), .CH_LSB(CH_LSB)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .dinS(dinS), .sampleBus(sampleBus),
    .doutBit(doutBit), .doutEn(doutEn)
  );

  assign dout = doutEn ? doutBit : 1'bz;

  // R1
  shift_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftOut |=> doutEn);

endmodule

// File: tb/tb_adc4SerialResponder.sv
module tb_adc4SerialResponder;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0, csN = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [7:0] smp [4];
  logic [31:0] sampleBus;
  wire dout, doutEn;
  int checks = 0, errors = 0;
  int csHighCnt = 0, csLowCnt = 0;
  int pending = 0;                 // reference model: next channel
  logic [7:0] ctrlBytes [8];

  always #10 clk = ~clk;           // 50 MHz

  assign sampleBus = {smp[3], smp[2], smp[1], smp[0]};

  adc4SerialResponder dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .sampleBus(sampleBus), .dout(dout), .doutEn(doutEn)
  );

  task automatic check(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: per-clock comparison of the enable against the settled chip select
  always @(posedge clk) begin
    csHighCnt <= csN ? csHighCnt + 1 : 0;
    csLowCnt  <= csN ? 0 : csLowCnt + 1;
  end
  always @(negedge clk) begin
    if (rstN && csHighCnt >= 6) check("R1 enable while deselected", doutEn, 1'b0);
    if (rstN && csLowCnt >= 6)  check("R1 enable while selected", doutEn, 1'b1);
  end

  // One frame; abortAt = number of rising edges after which chip select rises (0: none)
  task automatic runFrame(input string tag, input bit idleHigh, input int nSlots,
                          input int abortAt);
    int rises = 0;
    bit stop = 0;
    int curChan = 0;
    logic [7:0] curVal = 8'h00;
    logic exp;
    sclk = idleHigh;
    waitClk(2 * HALF);
    for (int s = 0; s < nSlots && !stop; s++) begin
      for (int k = 1; k <= 16 && !stop; k++) begin
        din = (k <= 8) ? ctrlBytes[s][8-k] : 1'b1;
        if (s == 0 && k == 1) begin
          csN = 1'b0;                       // R8: stands in for fall 1 if clock low
          if (idleHigh) begin waitClk(HALF); sclk = 1'b0; end
        end else begin
          sclk = 1'b0;
        end
        if (k == 4) begin curChan = pending; curVal = smp[pending]; end  // R6
        waitClk(HALF);
        exp = (k >= 5 && k <= 12) ? curVal[12-k] : 1'b0;
        check($sformatf("%s R5 slot %0d clock %0d enable", tag, s, k), doutEn, 1'b1);
        check($sformatf("%s R5 slot %0d clock %0d ch %0d data", tag, s, k, curChan),
              dout, exp);
        sclk = 1'b1;
        rises++;
        if (k == 8) pending = int'(ctrlBytes[s][4:3]);   // R3
        waitClk(HALF);
        if (abortAt != 0 && rises == abortAt) stop = 1;
      end
    end
    csN = 1'b1;
    waitClk(HALF);
    if (!idleHigh) sclk = 1'b0;
    waitClk(2 * HALF);
    check($sformatf("%s R1 released after frame", tag), doutEn, 1'b0);
  endtask

  initial begin
    smp[0] = 8'h3C; smp[1] = 8'hA5; smp[2] = 8'h5A; smp[3] = 8'hC3;
    for (int i = 0; i < 8; i++) ctrlBytes[i] = 8'h00;
    waitClk(5);
    check("R1 reset enable", doutEn, 1'b0);
    rstN = 1'b1;
    waitClk(10);
    check("R1 idle enable", doutEn, 1'b0);

    // R4: first conversion uses channel 0
    ctrlBytes[0] = 8'h10;
    runFrame("R4", 1'b1, 1, 0);

    // R7: back-to-back slots, each byte selects the next slot
    ctrlBytes[0] = 8'h18; ctrlBytes[1] = 8'h08; ctrlBytes[2] = 8'h00;
    runFrame("R7", 1'b1, 3, 0);

    // R8: clock parked low; R3: don't-care bits set
    ctrlBytes[0] = 8'hE7; ctrlBytes[1] = 8'h1F;
    runFrame("R8", 1'b0, 2, 0);
    ctrlBytes[0] = 8'h24;
    runFrame("R3", 1'b1, 1, 0);

    // R2: boundary sample values, din held 1 after the 8th rise
    smp[0] = 8'hFF; smp[1] = 8'h00; smp[2] = 8'h80; smp[3] = 8'h01;
    ctrlBytes[0] = 8'h10;
    runFrame("R2", 1'b0, 1, 0);
    ctrlBytes[0] = 8'h00;
    runFrame("R2", 1'b1, 1, 0);           // channel 2 = 0x80

    // R9: abort before the byte completes, then exactly at its 8th bit
    ctrlBytes[0] = 8'h18;
    runFrame("R9", 1'b1, 1, 5);
    ctrlBytes[0] = 8'h08;
    runFrame("R9", 1'b0, 1, 0);           // still channel 0, byte selects 1
    ctrlBytes[0] = 8'h18;
    runFrame("R9", 1'b1, 1, 8);           // commits channel 3
    ctrlBytes[0] = 8'h00;
    runFrame("R9", 1'b1, 1, 0);           // channel 3 = 0x01

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule